// File: doc/BRIEF.md
# Split-Access 64-bit Event Timebase

This block keeps a 64-bit time count for a multiprocessor scheduler and exposes it on a 32-bit memory-mapped register bus. The count advances once every programmable number of clocks. Two 64-bit compare values sit next to it: an event time and a freeze threshold. Reaching the event time raises a sticky event flag. Reaching the freeze threshold, when freezing is armed, stops the count until software releases it. A debug hold can also stop the count.

All 64-bit values cross the 32-bit bus through a low-word sample register. Each bus master has its own sample register, selected by a master ID on the bus. Reading any high-word register copies the matching low word into that master's sample register in the same clock. The two halves therefore come from one instant. Writing a high word commits it together with the master's sample register as a single 64-bit update.

The control register takes command codes on write and returns status bits on read. A 32-bit elapsed register reports the time since it was last read.

Top module: `evt_timebase`

## Requirements
- R1: After reset the count, prescale value, elapsed reference, event flag, freeze-active, freeze-enable and debug-hold are all zero. The event time and the freeze threshold are all ones.
- R2: With prescale value P at address 4 (read/write), the count rises by exactly one every P+1 clocks and by no more. After a counter clear, the count read k clocks later is floor(k/(P+1)).
- R3: A read of a high-word register returns bits 63:32 and copies the matching bits 31:0 into the reading master's sample register (address 0). The high-word registers are count at 1, event time at 2 and freeze threshold at 3.
- R4: A write to address 2 or 3 loads that register with {written data, writing master's sample register} in one clock. A master may also write its sample register directly at address 0.
- R5: Sample registers are per master: a write or a latch by one master ID leaves the sample register of every other master unchanged.
- R6: The event flag (address 6, bit 0, also port event_hit) sets within one clock once count is greater than or equal to the event time. It stays set until the event time is written, and that write clears it.
- R7: With freeze armed, the count stops at the freeze threshold and freeze-active sets when the count steps onto that threshold. Command 3 clears freeze-active and counting resumes. With freeze disarmed the count passes the threshold.
- R8: While debug hold is on, the count does not change.
- R9: Control writes (address 5) are commands: 1 arms freeze, 2 disarms it, 3 clears freeze-active, 4 clears the count and the prescale phase, 6 sets debug hold and 7 clears it. Other codes are ignored.
- R10: A control read returns bit 0 freeze-active, bit 1 freeze-armed and bit 2 debug hold, with all other bits zero.
- R11: A read of address 7 returns the low 32 bits of count minus a reference, then moves the reference to the current count. Command 4 zeroes the reference.
- R12: Read data appears on bus_rdata the clock after bus_rd is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_addr | input | ADDR_W | Register address |
| bus_mid | input | MID_W | Issuing master ID |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| event_hit | output | 1 | Sticky event flag |
| freeze_hit | output | 1 | Freeze active |

## Verification
Read data is registered, so every read result is sampled one clock after the strobe edge, at the falling edge that follows it. A latched low word belongs to the same rising edge as its high word. The bench counts rising edges from the edge that performs the clear command, and computes each expected count as floor(k/(P+1)). The event flag lags its compare by one register, so its checks sample well before and well after the event time, where the value is unambiguous. A freeze takes effect on the same edge that lands on the threshold, so the frozen count must equal the threshold exactly.

// File: rtl/evt_timebase_pkg.sv
package evt_timebase_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_SAMPLE  = 4'd0,
    RG_CNT_HI  = 4'd1,
    RG_EVT_HI  = 4'd2,
    RG_FRZ_HI  = 4'd3,
    RG_PSC     = 4'd4,
    RG_CTRL    = 4'd5,
    RG_EVT     = 4'd6,
    RG_ELAPSED = 4'd7
  } reg_addr_e;

  localparam logic [31:0] CMD_FRZ_ARM   = 32'd1;
  localparam logic [31:0] CMD_FRZ_DISARM = 32'd2;
  localparam logic [31:0] CMD_FRZ_CLR   = 32'd3;
  localparam logic [31:0] CMD_CNT_CLR   = 32'd4;
  localparam logic [31:0] CMD_DBG_ON    = 32'd6;
  localparam logic [31:0] CMD_DBG_OFF   = 32'd7;
endpackage

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 64,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] count,
  output logic             adv
);
  logic [PSC_W-1:0] phase_q;

  // a lowered prescale value still fires at once thanks to >=
  assign adv = !hold && (phase_q >= psc);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
      count   <= '0;
    end else if (!hold) begin
      phase_q <= adv ? '0 : phase_q + 1'b1;
      if (adv) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/evt_match_unit.sv
module evt_match_unit #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             adv,
  input  logic [CNT_W-1:0] evt_time,
  input  logic [CNT_W-1:0] frz_thr,
  input  logic             evt_wr,
  input  logic             frz_armed,
  input  logic             frz_clr,
  output logic             evt_flag,
  output logic             frz_act
);
  logic lands_on_thr;
  assign lands_on_thr = adv && ((count + 1'b1) == frz_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_flag <= 1'b0;
      frz_act  <= 1'b0;
    end else begin
      if (evt_wr) evt_flag <= 1'b0;
      else if (count >= evt_time) evt_flag <= 1'b1;

      if (frz_clr) frz_act <= 1'b0;
      else if (frz_armed && lands_on_thr) frz_act <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_sample_bank.sv
module evt_sample_bank #(
  parameter int N_MST = 4,
  parameter int W     = 32,
  localparam int SEL_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);
  // one write port, one read port on the same index: maps to distributed RAM
  logic [W-1:0] mem [N_MST];

  always_ff @(posedge clk) begin
    if (we) mem[sel] <= wdata;
  end

  assign rdata = mem[sel];
endmodule

// File: rtl/evt_timebase.sv
module evt_timebase
  import evt_timebase_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int PSC_W = 16,
  localparam int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int CNT_W = 64,
  localparam int HALF  = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic [HALF-1:0]   bus_wdata,
  output logic [HALF-1:0]   bus_rdata,
  output logic              event_hit,
  output logic              freeze_hit
);
  logic [CNT_W-1:0] count_w;
  logic             adv_w;
  logic [CNT_W-1:0] evt_time_q, frz_thr_q;
  logic [PSC_W-1:0] psc_q;
  logic             frz_armed_q, dbg_q;
  logic [HALF-1:0]  ref_q;
  logic [HALF-1:0]  sample_rd, sample_wd, low_pick;
  logic             sample_we;

  logic wr_sample, wr_evt, wr_frz, wr_psc, wr_ctrl, rd_hi, rd_elapsed;
  logic cnt_clr, frz_clr;

  assign wr_sample  = bus_wr && (bus_addr == RG_SAMPLE);
  assign wr_evt     = bus_wr && (bus_addr == RG_EVT_HI);
  assign wr_frz     = bus_wr && (bus_addr == RG_FRZ_HI);
  assign wr_psc     = bus_wr && (bus_addr == RG_PSC);
  assign wr_ctrl    = bus_wr && (bus_addr == RG_CTRL);
  assign rd_elapsed = bus_rd && (bus_addr == RG_ELAPSED);
  assign rd_hi      = bus_rd && (bus_addr == RG_CNT_HI || bus_addr == RG_EVT_HI ||
                                 bus_addr == RG_FRZ_HI);

  assign cnt_clr = wr_ctrl && (bus_wdata == CMD_CNT_CLR);
  assign frz_clr = wr_ctrl && (bus_wdata == CMD_FRZ_CLR);

  always_comb begin
    unique case (bus_addr)
      RG_EVT_HI: low_pick = evt_time_q[HALF-1:0];
      RG_FRZ_HI: low_pick = frz_thr_q[HALF-1:0];
      default:   low_pick = count_w[HALF-1:0];
    endcase
  end

  assign sample_we = wr_sample || rd_hi;
  assign sample_wd = wr_sample ? bus_wdata : low_pick;

  evt_sample_bank #(.N_MST(N_MST), .W(HALF)) u_bank (
    .clk  (clk),
    .we   (sample_we),
    .sel  (bus_mid),
    .wdata(sample_wd),
    .rdata(sample_rd)
  );

  evt_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .hold (freeze_hit || dbg_q),
    .psc  (psc_q),
    .count(count_w),
    .adv  (adv_w)
  );

  evt_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .count    (count_w),
    .adv      (adv_w),
    .evt_time (evt_time_q),
    .frz_thr  (frz_thr_q),
    .evt_wr   (wr_evt),
    .frz_armed(frz_armed_q),
    .frz_clr  (frz_clr),
    .evt_flag (event_hit),
    .frz_act  (freeze_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_time_q  <= '1;
      frz_thr_q   <= '1;
      psc_q       <= '0;
      frz_armed_q <= 1'b0;
      dbg_q       <= 1'b0;
      ref_q       <= '0;
    end else begin
      if (wr_evt) evt_time_q <= {bus_wdata, sample_rd};
      if (wr_frz) frz_thr_q  <= {bus_wdata, sample_rd};
      if (wr_psc) psc_q      <= bus_wdata[PSC_W-1:0];
      if (wr_ctrl) begin
        case (bus_wdata)
          CMD_FRZ_ARM:    frz_armed_q <= 1'b1;
          CMD_FRZ_DISARM: frz_armed_q <= 1'b0;
          CMD_DBG_ON:     dbg_q       <= 1'b1;
          CMD_DBG_OFF:    dbg_q       <= 1'b0;
          default: ;
        endcase
      end
      if (cnt_clr) ref_q <= '0;
      else if (rd_elapsed) ref_q <= count_w[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RG_SAMPLE:  bus_rdata <= sample_rd;
        RG_CNT_HI:  bus_rdata <= count_w[CNT_W-1:HALF];
        RG_EVT_HI:  bus_rdata <= evt_time_q[CNT_W-1:HALF];
        RG_FRZ_HI:  bus_rdata <= frz_thr_q[CNT_W-1:HALF];
        RG_PSC:     bus_rdata <= HALF'(psc_q);
        RG_CTRL:    bus_rdata <= {{(HALF-3){1'b0}}, dbg_q, frz_armed_q, freeze_hit};
        RG_EVT:     bus_rdata <= {{(HALF-1){1'b0}}, event_hit};
        RG_ELAPSED: bus_rdata <= count_w[HALF-1:0] - ref_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_timebase_chk.sv
module evt_timebase_chk (
  input logic        clk,
  input logic        rst,
  input logic [63:0] count,
  input logic [63:0] thr,
  input logic        event_hit,
  input logic        freeze_hit,
  input logic        dbg,
  input logic        evt_wr,
  input logic        clr
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dbg || freeze_hit) && !clr |=> $stable(count));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + 64'd1));

  assert_evt_clear_R6: assert property (@(posedge clk) disable iff (rst)
    evt_wr |=> !event_hit);

  assert_evt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    event_hit && !evt_wr |=> event_hit);

  assert_freeze_at_thr_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_hit) && $stable(thr) |-> count == thr);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == 64'd0);
endmodule

bind evt_timebase evt_timebase_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .count     (count_w),
  .thr       (frz_thr_q),
  .event_hit (event_hit),
  .freeze_hit(freeze_hit),
  .dbg       (dbg_q),
  .evt_wr    (wr_evt),
  .clr       (cnt_clr)
);

// File: tb/evt_timebase_test.sv
module evt_timebase_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_MST = 4;
  localparam int MID_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [MID_W-1:0] bus_mid = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic event_hit, freeze_hit;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  evt_timebase #(.N_MST(N_MST), .PSC_W(16)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_mid(bus_mid), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .event_hit(event_hit), .freeze_hit(freeze_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [MID_W-1:0] m = 0);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_mid = m;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [MID_W-1:0] m = 0);
    bus_rd = 1'b1; bus_addr = a; bus_mid = m;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_count(output logic [31:0] hi, output logic [31:0] lo);
    rd(4'd1, hi);
    rd(4'd0, lo);
  endtask

  logic [31:0] d, hi, lo, c1, c2;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check({31'd0, event_hit}, 32'd0, "R1 event port");
    check({31'd0, freeze_hit}, 32'd0, "R1 freeze port");
    rd(4'd5, d); check(d, 32'd0, "R1 status");
    rd(4'd4, d); check(d, 32'd0, "R1 prescale");
    rd(4'd2, d); check(d, 32'hFFFF_FFFF, "R1 event time hi");
    rd(4'd0, d); check(d, 32'hFFFF_FFFF, "R1 event time lo via sample R3");
    rd(4'd3, d); check(d, 32'hFFFF_FFFF, "R1 threshold hi");
    rd(4'd6, d); check(d, 32'd0, "R1 event reg");

    // R2/R3/R9/R12: prescale sweep with clear and split count read
    for (int p = 0; p < 5; p++) begin
      wr(4'd4, p);
      rd(4'd4, d); check(d, p, "R2 prescale readback");
      for (int w = 0; w < 11; w++) begin
        wr(4'd5, 32'd4);
        repeat (w) @(negedge clk);
        rd_count(hi, lo);
        check(hi, 32'd0, "R3 count hi");
        check(lo, w / (p + 1), "R2 R9 count lo after clear");
      end
    end

    // R9: unknown command codes ignored
    wr(4'd4, 0);
    wr(4'd5, 32'd5); wr(4'd5, 32'd0); wr(4'd5, 32'd9);
    rd(4'd5, d); check(d, 32'd0, "R9 ignored codes leave status");

    // R4: 64-bit commit via sample then high word
    wr(4'd0, 32'hDEAD_BEEF);
    wr(4'd3, 32'h1234_5678);
    rd(4'd3, d); check(d, 32'h1234_5678, "R4 threshold hi");
    rd(4'd0, d); check(d, 32'hDEAD_BEEF, "R4 threshold lo");
    wr(4'd0, 32'h0BAD_F00D);
    wr(4'd2, 32'h0000_0007);
    rd(4'd2, d); check(d, 32'h7, "R4 event hi");
    rd(4'd0, d); check(d, 32'h0BAD_F00D, "R4 event lo");

    // R5: per-master samples
    for (int m = 0; m < N_MST; m++) wr(4'd0, 32'hA0 + m, m[MID_W-1:0]);
    rd(4'd1, d, 2'd2);
    for (int m = 0; m < N_MST; m++) begin
      rd(4'd0, d, m[MID_W-1:0]);
      if (m != 2) check(d, 32'hA0 + m, "R5 sample isolation");
    end

    // R6: event flag
    wr(4'd5, 32'd4);
    wr(4'd0, 32'd20);
    wr(4'd2, 32'd0);
    rd(4'd6, d); check(d, 32'd0, "R6 event before time");
    repeat (30) @(negedge clk);
    rd(4'd6, d); check(d, 32'd1, "R6 event after time");
    check({31'd0, event_hit}, 32'd1, "R6 event port");
    repeat (5) @(negedge clk);
    rd(4'd6, d); check(d, 32'd1, "R6 event sticky");
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd6, d); check(d, 32'd0, "R6 event cleared by rewrite");

    // R7/R10: freeze
    wr(4'd0, 32'd10);
    wr(4'd3, 32'd0);
    wr(4'd5, 32'd4);
    wr(4'd5, 32'd1);
    repeat (30) @(negedge clk);
    rd_count(hi, lo);
    check(lo, 32'd10, "R7 count frozen at threshold");
    check({31'd0, freeze_hit}, 32'd1, "R7 freeze port");
    rd(4'd5, d); check(d, 32'd3, "R10 status armed and active");
    wr(4'd5, 32'd3);
    repeat (5) @(negedge clk);
    rd_count(hi, lo);
    check({31'd0, lo > 32'd10}, 32'd1, "R7 count resumes after clear");
    rd(4'd5, d); check(d, 32'd2, "R10 status armed only");
    wr(4'd5, 32'd2);
    wr(4'd5, 32'd4);
    repeat (30) @(negedge clk);
    rd_count(hi, lo);
    check({31'd0, lo > 32'd10}, 32'd1, "R7 disarmed passes threshold");
    rd(4'd5, d); check(d, 32'd0, "R10 status disarmed");

    // R8: debug hold
    wr(4'd5, 32'd6);
    rd(4'd5, d); check(d, 32'd4, "R10 status debug hold");
    rd_count(hi, c1);
    repeat (10) @(negedge clk);
    rd_count(hi, c2);
    check(c2, c1, "R8 count held");
    wr(4'd5, 32'd7);
    repeat (5) @(negedge clk);
    rd_count(hi, c2);
    check({31'd0, c2 > c1}, 32'd1, "R8 count resumes");

    // R11: elapsed interval
    wr(4'd5, 32'd4);
    rd(4'd7, d); check(d, 32'd0, "R11 elapsed after clear");
    for (int w = 0; w < 5; w++) begin
      repeat (w) @(negedge clk);
      rd(4'd7, d); check(d, w + 1, "R11 elapsed interval");
    end

    // R12: read data holds after the strobe
    rd(4'd4, d);
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'd0, "R12 read data holds");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule